// File: doc/BRIEF.md
# Dual-Encoding Ternary Word Shifter

The block holds a word of ternary digits (trits) and moves it by one trit position per clock cycle, either toward the most significant end (multiply by three) or toward the least significant end (divide by three). Each trit is carried on a pair of wires. A mode input chooses how the word is read. In complement mode the digits 0, 1 and 2 are weighted as in radix-3 three's-complement arithmetic, so a word with 2 in its top position is negative. In balanced mode the digits are −1, 0 and +1, and the sign is that of the highest nonzero trit.

A parallel load writes a new word. A hold leaves the register alone. When a left shift pushes the top trit out, a separate one-trit register keeps it. A flag reports whether losing that trit changed the value. Shift sequences can be used as the multiply-by-three and divide-by-three steps of a radix-3 multiplier or divider.

Top module: `tshift_unit`

## Requirements
- R1: While reset is asserted, and until the first request after release, the word output, the lost-trit output and the overflow flag are all zero.
- R2: Trit codes are 2'b00, 2'b01 and 2'b10 for digits 0, 1 and 2 in complement mode, and for 0, +1 and −1 in balanced mode. Trit i occupies bits 2i+1:2i. A load places din on the word in the next cycle and clears the lost trit and the flag. A load wins over any shift request in the same cycle.
- R3: A left shift without load moves every trit up one position, inserts code 00 at the bottom, and copies the outgoing top trit into the lost-trit output. This holds in both modes.
- R4: In complement mode a left shift sets the flag unless the old top two trits, read from the top down, were 00, 01 or 22. Otherwise it clears the flag. Equivalently, the flag is clear exactly when three times the signed value still fits in the word.
- R5: In balanced mode a left shift sets the flag when the outgoing trit is nonzero and clears it otherwise.
- R6: In complement mode a right shift drops the bottom trit and fills the top with 2 when the old top trit was 2, and with 0 otherwise. The result is floor(A/3).
- R7: In balanced mode a right shift drops the bottom trit and fills the top with 0. The result is A/3 rounded to the nearest integer.
- R8: When both shift requests are active without load, the left shift is performed.
- R9: With no request the word, the lost trit and the flag keep their values. A right shift leaves the lost trit and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bal | input | 1 | 1 selects balanced digits, 0 selects complement digits |
| load | input | 1 | Parallel load request |
| shl | input | 1 | Left shift request (multiply by 3) |
| shr | input | 1 | Right shift request (divide by 3) |
| din | input | 2*NTRITS | Word to load, two bits per trit |
| dout | output | 2*NTRITS | Current word |
| lost_trit | output | 2 | Trit pushed out by the last left shift |
| ovf_flag | output | 1 | The last left shift lost a significant trit |

## Verification
The assertions assume that every trit driven on din uses one of the three legal codes and never 2'b11. They also assume that the mode input stays steady across a shift whose result is checked, and that no request is issued in the two cycles that the reset needs to be released internally. The stimulus loads only words built from legal digit codes. It changes the mode only between complete sweeps and holds requests low for several cycles after reset. Every four-trit word is swept in both encodings, through load, left shift, hold and right shift.

// File: rtl/tsh_pkg.sv
package tsh_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_LEFT  = 2'd2,
    OP_RIGHT = 2'd3
  } tsh_op_e;

  localparam logic [1:0] TRIT_ZERO = 2'b00;
  localparam logic [1:0] TRIT_ONE  = 2'b01;
  localparam logic [1:0] TRIT_TWO  = 2'b10;
endpackage

// File: rtl/tsh_opsel.sv
module tsh_opsel
  import tsh_pkg::*;
(
  input  logic    load,
  input  logic    shl,
  input  logic    shr,
  output tsh_op_e op
);
  always_comb begin
    if (load)      op = OP_LOAD;
    else if (shl)  op = OP_LEFT;
    else if (shr)  op = OP_RIGHT;
    else           op = OP_HOLD;
  end
endmodule

// File: rtl/tsh_left.sv
module tsh_left
  import tsh_pkg::*;
#(
  parameter int NTRITS = 4
) (
  input  logic                  mode_bal,
  input  logic [2*NTRITS-1:0]   word_i,
  output logic [2*NTRITS-1:0]   word_o,
  output logic [1:0]            lost_o,
  output logic                  sig_o
);
  localparam int W = 2 * NTRITS;

  logic [1:0] top_t;
  logic [1:0] next_t;

  for (genvar i = 0; i < NTRITS; i++) begin : g_up
    if (i == 0) begin : g_bottom
      assign word_o[1:0] = TRIT_ZERO;
    end else begin : g_move
      assign word_o[2*i +: 2] = word_i[2*(i-1) +: 2];
    end
  end

  assign top_t  = word_i[W-1 -: 2];
  assign next_t = word_i[W-3 -: 2];
  assign lost_o = top_t;

  always_comb begin
    if (mode_bal) begin
      sig_o = (top_t != TRIT_ZERO);
    end else begin
      case ({top_t, next_t})
        {TRIT_ZERO, TRIT_ZERO},
        {TRIT_ZERO, TRIT_ONE},
        {TRIT_TWO,  TRIT_TWO}:  sig_o = 1'b0;
        default:                sig_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tsh_right.sv
module tsh_right
  import tsh_pkg::*;
#(
  parameter int NTRITS = 4
) (
  input  logic                  mode_bal,
  input  logic [2*NTRITS-1:0]   word_i,
  output logic [2*NTRITS-1:0]   word_o
);
  localparam int W = 2 * NTRITS;

  logic [1:0] fill_t;

  assign fill_t = (!mode_bal && (word_i[W-1 -: 2] == TRIT_TWO)) ? TRIT_TWO : TRIT_ZERO;

  for (genvar i = 0; i < NTRITS; i++) begin : g_down
    if (i == NTRITS - 1) begin : g_top
      assign word_o[2*i +: 2] = fill_t;
    end else begin : g_move
      assign word_o[2*i +: 2] = word_i[2*(i+1) +: 2];
    end
  end
endmodule

// File: rtl/tshift_unit.sv
module tshift_unit
  import tsh_pkg::*;
#(
  parameter int NTRITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_bal,
  input  logic                load,
  input  logic                shl,
  input  logic                shr,
  input  logic [2*NTRITS-1:0] din,
  output logic [2*NTRITS-1:0] dout,
  output logic [1:0]          lost_trit,
  output logic                ovf_flag
);
  localparam int W = 2 * NTRITS;

  logic [1:0]   rst_sync_q;
  logic         rst_int_n;

  tsh_op_e      op;
  logic [W-1:0] word_q, word_d, left_w, right_w;
  logic [1:0]   lost_q, lost_d, left_lost;
  logic         flag_q, flag_d, left_sig;
  logic         word_en, ovf_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tsh_opsel u_opsel (
    .load (load),
    .shl  (shl),
    .shr  (shr),
    .op   (op)
  );

  tsh_left #(.NTRITS(NTRITS)) u_left (
    .mode_bal (mode_bal),
    .word_i   (word_q),
    .word_o   (left_w),
    .lost_o   (left_lost),
    .sig_o    (left_sig)
  );

  tsh_right #(.NTRITS(NTRITS)) u_right (
    .mode_bal (mode_bal),
    .word_i   (word_q),
    .word_o   (right_w)
  );

  always_comb begin
    word_en = 1'b0;
    ovf_en  = 1'b0;
    word_d  = word_q;
    lost_d  = lost_q;
    flag_d  = flag_q;
    case (op)
      OP_LOAD: begin
        word_en = 1'b1;
        ovf_en  = 1'b1;
        word_d  = din;
        lost_d  = TRIT_ZERO;
        flag_d  = 1'b0;
      end
      OP_LEFT: begin
        word_en = 1'b1;
        ovf_en  = 1'b1;
        word_d  = left_w;
        lost_d  = left_lost;
        flag_d  = left_sig;
      end
      OP_RIGHT: begin
        word_en = 1'b1;
        word_d  = right_w;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      word_q <= '0;
      lost_q <= TRIT_ZERO;
      flag_q <= 1'b0;
    end else begin
      if (word_en) word_q <= word_d;
      if (ovf_en) begin
        lost_q <= lost_d;
        flag_q <= flag_d;
      end
    end
  end

  assign dout      = word_q;
  assign lost_trit = lost_q;
  assign ovf_flag  = flag_q;
endmodule

// File: rtl/tsh_chk.sv
module tsh_chk #(
  parameter int NTRITS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mode_bal,
  input logic                load,
  input logic                shl,
  input logic                shr,
  input logic [2*NTRITS-1:0] din,
  input logic [2*NTRITS-1:0] dout,
  input logic [1:0]          lost_trit,
  input logic                ovf_flag
);
  localparam int W = 2 * NTRITS;

  // R2
  load_takes_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (dout == $past(din)) && (lost_trit == 2'b00) && !ovf_flag);

  // R3
  left_moves_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shl) |=> (dout[1:0] == 2'b00) && (dout[W-1:2] == $past(dout[W-3:0]))
                       && (lost_trit == $past(dout[W-1 -: 2])));

  // R5
  bal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shl && mode_bal) |=> (ovf_flag == ($past(dout[W-1 -: 2]) != 2'b00)));

  // R4
  comp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shl && !mode_bal) |=> (ovf_flag != ($past(dout[W-1 -: 4]) inside {4'b0000, 4'b0001, 4'b1010})));

  // R7
  bal_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shl && shr && mode_bal) |=> (dout[W-1 -: 2] == 2'b00) && (dout[W-3:0] == $past(dout[W-1:2])));

  // R6
  comp_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shl && shr && !mode_bal) |=>
      (dout[W-3:0] == $past(dout[W-1:2])) &&
      ((dout[W-1 -: 2] == 2'b10) == ($past(dout[W-1 -: 2]) == 2'b10)) &&
      (dout[W-1 -: 2] != 2'b01));

  // R9
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shl && !shr) |=> $stable(dout) && $stable(lost_trit) && $stable(ovf_flag));

  // R9
  right_keeps_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shl && shr) |=> $stable(lost_trit) && $stable(ovf_flag));
endmodule

bind tshift_unit tsh_chk #(.NTRITS(NTRITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_bal  (mode_bal),
  .load      (load),
  .shl       (shl),
  .shr       (shr),
  .din       (din),
  .dout      (dout),
  .lost_trit (lost_trit),
  .ovf_flag  (ovf_flag)
);

// File: tb/sim_tshift_unit.sv
`timescale 1ns/1ps
module sim_tshift_unit;
  localparam int N = 4;
  localparam int W = 2 * N;
  localparam int M = 3 ** N;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_bal, load, shl, shr;
  logic [W-1:0] din;
  logic [W-1:0] dout;
  logic [1:0]   lost_trit;
  logic         ovf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  tshift_unit #(.NTRITS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_bal(mode_bal), .load(load), .shl(shl), .shr(shr),
    .din(din), .dout(dout), .lost_trit(lost_trit), .ovf_flag(ovf_flag)
  );

  function automatic logic [W-1:0] enc(input int idx);
    logic [W-1:0] r;
    int t;
    r = '0;
    t = idx;
    for (int i = 0; i < N; i++) begin
      r[2*i +: 2] = 2'(t % 3);
      t = t / 3;
    end
    return r;
  endfunction

  function automatic int fdiv3(input int x);
    return (x >= 0) ? x / 3 : -((-x + 2) / 3);
  endfunction

  function automatic int cval(input int idx);
    return (idx >= 2 * M / 3) ? idx - M : idx;
  endfunction

  function automatic int cidx(input int x);
    return (x < 0) ? x + M : x;
  endfunction

  function automatic int bval(input int idx);
    int s, p, t, d;
    s = 0; p = 1; t = idx;
    for (int i = 0; i < N; i++) begin
      d = t % 3;
      s += ((d == 2) ? -1 : d) * p;
      p *= 3;
      t /= 3;
    end
    return s;
  endfunction

  function automatic int bidx(input int x);
    int s, p, t, r;
    s = 0; p = 1; t = x;
    for (int i = 0; i < N; i++) begin
      r = ((t % 3) + 3) % 3;
      if (r == 2) begin s += 2 * p; t = (t + 1) / 3; end
      else if (r == 1) begin s += p; t = (t - 1) / 3; end
      else t = t / 3;
      p *= 3;
    end
    return s;
  endfunction

  function automatic int exp_left(input bit bal, input int idx);
    int top;
    top = idx / (M / 3);
    if (!bal) return cidx(((cval(idx) * 3) % M + M) % M >= 2 * M / 3
                          ? ((cval(idx) * 3) % M + M) % M - M
                          : ((cval(idx) * 3) % M + M) % M);
    return bidx((bval(idx) - ((top == 2) ? -1 : top) * (M / 3)) * 3);
  endfunction

  function automatic int exp_right(input bit bal, input int idx);
    if (!bal) return cidx(fdiv3(cval(idx)));
    return bidx(fdiv3(bval(idx) + 1));
  endfunction

  function automatic bit exp_flag(input bit bal, input int idx);
    int lim;
    if (!bal) return !((cval(idx) * 3 >= -(M / 3)) && (cval(idx) * 3 <= 2 * M / 3 - 1));
    lim = (M / 3 - 1) / 2;
    return (bval(idx) > lim) || (bval(idx) < -lim);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit ld, input bit l, input bit r, input logic [W-1:0] d);
    load = ld; shl = l; shr = r; din = d;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0; shl = 1'b0; shr = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int li, lw, rw;
    bit lf;
    rst_n = 1'b0; mode_bal = 1'b0; load = 1'b0; shl = 1'b0; shr = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 word", int'(dout), 0);
    chk("R1 lost", int'(lost_trit), 0);
    chk("R1 flag", int'(ovf_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 word after release", int'(dout), 0);

    for (int m = 0; m < 2; m++) begin
      mode_bal = m[0];
      @(negedge clk);
      for (int v = 0; v < M; v++) begin
        // R2 load
        step(1, 0, 0, enc(v));
        chk("R2 load word", int'(dout), int'(enc(v)));
        chk("R2 load clears flag", int'(ovf_flag), 0);
        // R3 left shift; R4 / R5 flag
        li = exp_left(m[0], v);
        lf = exp_flag(m[0], v);
        step(0, 1, 0, '0);
        chk("R3 left word", int'(dout), int'(enc(li)));
        chk("R3 lost trit", int'(lost_trit), v / (M / 3));
        chk(m[0] ? "R5 balanced flag" : "R4 complement flag", int'(ovf_flag), int'(lf));
        // R9 hold
        step(0, 0, 0, '0);
        chk("R9 hold word", int'(dout), int'(enc(li)));
        // R6 / R7 right shift; R9 ovf kept
        rw = exp_right(m[0], li);
        step(0, 0, 1, '0);
        chk(m[0] ? "R7 balanced right" : "R6 complement right", int'(dout), int'(enc(rw)));
        chk("R9 right keeps lost", int'(lost_trit), v / (M / 3));
        chk("R9 right keeps flag", int'(ovf_flag), int'(lf));
        // R6 / R7 right shift straight from the loaded word
        step(1, 0, 0, enc(v));
        step(0, 0, 1, '0);
        chk(m[0] ? "R7 right of load" : "R6 right of load", int'(dout), int'(enc(exp_right(m[0], v))));
      end
    end

    // R2 priority of load over both shifts
    mode_bal = 1'b0;
    step(1, 0, 0, enc(40));
    step(0, 1, 0, '0);
    step(1, 1, 1, enc(55));
    chk("R2 load wins word", int'(dout), int'(enc(55)));
    chk("R2 load wins flag", int'(ovf_flag), 0);
    chk("R2 load wins lost", int'(lost_trit), 0);
    // R8 left wins over right
    step(0, 1, 1, '0);
    chk("R8 left wins", int'(dout), int'(enc(exp_left(1'b0, 55))));
    mode_bal = 1'b1;
    step(1, 0, 0, enc(7));
    lw = 7;
    for (int k = 0; k < 3; k++) begin
      step(0, 1, 1, '0);
      lw = exp_left(1'b1, lw);
      chk("R8 left wins balanced", int'(dout), int'(enc(lw)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule